// File: doc/BRIEF.md
# Unaligned Vector Byte Aligner

This block moves sixteen bytes between a 128-bit vector register and a 4 KB byte-addressed data memory. The register is organised as eight 16-bit lanes. The memory is reached through a synchronous port that reads or writes one 64-bit doubleword per cycle, and read data returns one cycle after the request.

A single start pulse captures these inputs:

- the byte address
- a starting element index (0 to 15)
- a 16-bit byte enable
- the vector operand
- the direction (load or store)

An access whose address is not doubleword-aligned covers a 16-byte window made of two neighbouring doublewords. The second doubleword wraps around the top of the 4 KB space.

On a load, the block rotates the window bytes into register order and merges them into the captured vector under the shifted enable. The result appears on `vreg_out`. On a store, it rotates the vector bytes into window order and merges them into the doublewords it has just read. It then writes those doublewords back with a read-modify-write.

A busy/done handshake frames each operation. The controlling pipeline starts a new access only after it sees `done`.

Top module: `vec_byte_aligner`

## Requirements
- R1: After reset, `busy`, `done`, `mem_en` and `mem_we` are low and `vreg_out` is all zero.
- R2: When `addr[2:0]` is zero, exactly one doubleword is read, at index `addr[11:3]`. `done` follows the accepted start by 3 cycles for a load and by 4 cycles for a store.
- R3: When `addr[2:0]` is nonzero, index `addr[11:3]` is read first and then index (`addr[11:3]`+1) mod 512. `done` follows the accepted start by 4 cycles for a load and by 6 cycles for a store.
- R4: Byte order in the register:
  - Vector byte j occupies `vreg` bits [127-8j : 120-8j], so lane j/2 has its even byte in the high half.
  - Enable bit j (bit 0 = LSB) belongs to byte j.
- R5: Byte order in memory and in the window:
  - Memory byte 8d+k sits in doubleword d at bits [63-8k : 56-8k].
  - Window bytes 0..7 come from the lower doubleword and bytes 8..15 from the upper one.
  - On a load with zero offset, window bytes 8..15 read as zero.
- R6: On a load, vector byte j is enabled when j >= elem and enable bit (j-elem) is set. An enabled byte takes window byte (j + offset - elem) mod 16.
- R7: On a load, disabled bytes keep the value `vreg_in` had at start. A store leaves `vreg_out` unchanged.
- R8: On a store, window byte k is written when k >= offset and enable bit (k-offset) is set. The value written is vector byte (k + elem - offset) mod 16. Every other memory byte keeps its value.
- R9: Edge cases of the store write-back:
  - With a nonzero offset, the store writes the lower doubleword and then the wrapped upper one.
  - With a zero offset, only the lower doubleword is written.
  - Enable bits shifted past byte 15 are dropped and never wrap into low positions.
- R10: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start until the cycle before `done`. A start while the block is not idle is ignored.
- R11: A load never asserts `mem_we`, and no memory byte changes during a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an access; accepted only when idle |
| is_store | input | 1 | 1 = store register to memory, 0 = load |
| addr | input | 12 | Byte address |
| elem | input | 4 | Starting vector byte index |
| byte_en | input | 16 | Byte enable, bit j for vector byte j |
| vreg_in | input | 128 | Vector operand (load merge base or store source) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| vreg_out | output | 128 | Result of the last load |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 9 | Doubleword index |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
Results become due a fixed number of cycles after the start edge, and that number depends only on the direction and on whether the offset is zero:
- 3 cycles for an aligned load, 4 for an unaligned load
- 4 cycles for an aligned store, 6 for an unaligned store

Both the load result and the written memory are therefore in place in the `done` cycle.

The bench computes this latency from the request. It compares `busy` and `done` against the expected schedule in every cycle between the start and the expected `done`. It checks `vreg_out` and the whole memory image exactly in the `done` cycle, against a byte-level model.

The inputs are scrambled right after the start edge, which checks that the block works only from the values it captured.

// File: rtl/vba_pkg.sv
package vba_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_RD_HI = 3'd2,
    ST_LAST  = 3'd3,
    ST_WR_LO = 3'd4,
    ST_WR_HI = 3'd5,
    ST_FIN   = 3'd6
  } vba_state_e;

endpackage

// File: rtl/vba_byte_rotator.sv
// Output byte j takes input byte (j + amt) mod N_BYTES; byte 0 is the MSB byte.
// N_BYTES must be a power of two so the modulo is a plain wrap of amt.
module vba_byte_rotator #(
  parameter int N_BYTES = 16,
  parameter int SH_W    = $clog2(N_BYTES)
) (
  input  logic [N_BYTES*vba_pkg::BYTE_W-1:0] din,
  input  logic [SH_W-1:0]                    amt,
  output logic [N_BYTES*vba_pkg::BYTE_W-1:0] dout
);
  localparam int BW = vba_pkg::BYTE_W;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
    logic [SH_W-1:0] src;
    assign src = SH_W'(j) + amt;
    assign dout[(N_BYTES-1-j)*BW +: BW] = din[(N_BYTES-1-int'(src))*BW +: BW];
  end

endmodule

// File: rtl/vba_byte_merge.sv
// Byte-wise select: enabled bytes take fresh, others keep base.
module vba_byte_merge #(
  parameter int N_BYTES = 16
) (
  input  logic [N_BYTES*vba_pkg::BYTE_W-1:0] base,
  input  logic [N_BYTES*vba_pkg::BYTE_W-1:0] fresh,
  input  logic [N_BYTES-1:0]                 en,
  output logic [N_BYTES*vba_pkg::BYTE_W-1:0] dout
);
  localparam int BW = vba_pkg::BYTE_W;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
    assign dout[(N_BYTES-1-j)*BW +: BW] =
      en[j] ? fresh[(N_BYTES-1-j)*BW +: BW] : base[(N_BYTES-1-j)*BW +: BW];
  end

endmodule

// File: rtl/vec_byte_aligner.sv
module vec_byte_aligner
  import vba_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DW_BYTES = 8,
  localparam int VEC_BYTES = 2 * DW_BYTES,
  localparam int OFF_W     = $clog2(DW_BYTES),
  localparam int EL_W      = $clog2(VEC_BYTES),
  localparam int IDX_W     = ADDR_W - OFF_W,
  localparam int DW_W      = DW_BYTES * BYTE_W,
  localparam int VEC_W     = VEC_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_store,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [EL_W-1:0]      elem,
  input  logic [VEC_BYTES-1:0] byte_en,
  input  logic [VEC_W-1:0]     vreg_in,
  output logic                 busy,
  output logic                 done,
  output logic [VEC_W-1:0]     vreg_out,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [IDX_W-1:0]     mem_addr,
  output logic [DW_W-1:0]      mem_wdata,
  input  logic [DW_W-1:0]      mem_rdata
);

  // reset synchroniser: assert asynchronously, release on clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  vba_state_e             state_q, state_d;
  logic                   st_q;
  logic [IDX_W-1:0]       idx_q;
  logic [OFF_W-1:0]       off_q;
  logic [EL_W-1:0]        elem_q;
  logic [VEC_BYTES-1:0]   en_q;
  logic [VEC_W-1:0]       vreg_q;
  logic [DW_W-1:0]        lo_q;
  logic [VEC_W-1:0]       wbuf_q;
  logic [VEC_W-1:0]       vout_q;

  logic                   accept;
  logic                   two_dw;
  logic [VEC_W-1:0]       window;
  logic [VEC_W-1:0]       rot_in, rot_out;
  logic [EL_W-1:0]        rot_amt;
  logic [EL_W-1:0]        off_ext;
  logic [VEC_BYTES-1:0]   merge_en;
  logic [VEC_W-1:0]       merge_base, merged;
  logic                   cap_op, cap_lo, cap_wbuf, cap_vout;

  assign accept  = (state_q == ST_IDLE) && start;
  assign two_dw  = (off_q != '0);
  assign off_ext = {{(EL_W-OFF_W){1'b0}}, off_q};

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_RD_LO;
      ST_RD_LO: state_d = two_dw ? ST_RD_HI : ST_LAST;
      ST_RD_HI: state_d = ST_LAST;
      ST_LAST:  state_d = st_q ? ST_WR_LO : ST_FIN;
      ST_WR_LO: state_d = two_dw ? ST_WR_HI : ST_FIN;
      ST_WR_HI: state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // window as seen in ST_LAST: the last read's data arrives on mem_rdata
  assign window = two_dw ? {lo_q, mem_rdata} : {mem_rdata, {DW_W{1'b0}}};

  // one rotator and one merger shared by both directions
  always_comb begin
    if (st_q) begin
      rot_in     = vreg_q;
      rot_amt    = elem_q - off_ext;
      merge_en   = en_q << off_q;
      merge_base = window;
    end else begin
      rot_in     = window;
      rot_amt    = off_ext - elem_q;
      merge_en   = en_q << elem_q;
      merge_base = vreg_q;
    end
  end

  vba_byte_rotator #(.N_BYTES(VEC_BYTES)) u_rot (
    .din  (rot_in),
    .amt  (rot_amt),
    .dout (rot_out)
  );

  vba_byte_merge #(.N_BYTES(VEC_BYTES)) u_merge (
    .base  (merge_base),
    .fresh (rot_out),
    .en    (merge_en),
    .dout  (merged)
  );

  // clock enables
  assign cap_op   = accept;
  assign cap_lo   = (state_q == ST_RD_HI);
  assign cap_wbuf = (state_q == ST_LAST) && st_q;
  assign cap_vout = (state_q == ST_LAST) && !st_q;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      st_q    <= 1'b0;
      idx_q   <= '0;
      off_q   <= '0;
      elem_q  <= '0;
      en_q    <= '0;
      vreg_q  <= '0;
      lo_q    <= '0;
      wbuf_q  <= '0;
      vout_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cap_op) begin
        st_q   <= is_store;
        idx_q  <= addr[ADDR_W-1:OFF_W];
        off_q  <= addr[OFF_W-1:0];
        elem_q <= elem;
        en_q   <= byte_en;
        vreg_q <= vreg_in;
      end
      if (cap_lo)   lo_q   <= mem_rdata;
      if (cap_wbuf) wbuf_q <= merged;
      if (cap_vout) vout_q <= merged;
    end
  end

  // memory port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = idx_q;
    mem_wdata = wbuf_q[VEC_W-1 -: DW_W];
    unique case (state_q)
      ST_RD_LO: mem_en = 1'b1;
      ST_RD_HI: begin
        mem_en   = 1'b1;
        mem_addr = idx_q + IDX_W'(1);
      end
      ST_WR_LO: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      ST_WR_HI: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = idx_q + IDX_W'(1);
        mem_wdata = wbuf_q[DW_W-1:0];
      end
      default: ;
    endcase
  end

  assign busy     = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done     = (state_q == ST_FIN);
  assign vreg_out = vout_q;

endmodule

// File: rtl/vba_checker.sv
module vba_checker
  import vba_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic [VEC_W-1:0] vreg_out,
  input logic             st_q,
  input vba_state_e       state_q
);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R10

  AST_NO_WRITE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> st_q); // R11

  AST_UPPER_DW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_HI) |-> (mem_addr == $past(mem_addr) + IDX_W'(1))); // R3

  AST_VOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || st_q) |-> $stable(vreg_out)); // R7

endmodule

bind vec_byte_aligner vba_checker #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_vba_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .vreg_out (vreg_out),
  .st_q     (st_q),
  .state_q  (state_q)
);

// File: tb/sim_vec_byte_aligner.sv
`timescale 1ns/1ps
module sim_vec_byte_aligner;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         is_store;
  logic [11:0]  addr;
  logic [3:0]   elem;
  logic [15:0]  byte_en;
  logic [127:0] vreg_in;
  logic         busy, done;
  logic [127:0] vreg_out;
  logic         mem_en, mem_we;
  logic [8:0]   mem_addr;
  logic [63:0]  mem_wdata;
  logic [63:0]  mem_rdata;

  always #2 clk = ~clk; // 250 MHz

  vec_byte_aligner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .addr(addr), .elem(elem), .byte_en(byte_en), .vreg_in(vreg_in),
    .busy(busy), .done(done), .vreg_out(vreg_out),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_byte(input int i);
    return 8'((i * 37) ^ ((i >> 4) * 11) ^ 8'h5a);
  endfunction

  // memory model: byte array, synchronous one-cycle read
  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= seed_byte(i);
    end else if (mem_en) begin
      for (int k = 0; k < 8; k++) begin
        if (mem_we) mem[int'(mem_addr)*8 + k] <= mem_wdata[63-8*k -: 8];
        else        mem_rdata[63-8*k -: 8]    <= mem[int'(mem_addr)*8 + k];
      end
    end
  end

  // reference state
  logic [7:0]   ref_mem [4096];
  logic [127:0] vout_model;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           finished = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int win_addr(input int lo, input int k);
    if (k < 8) return lo * 8 + k;
    return ((lo + 1) % 512) * 8 + (k - 8);
  endfunction

  task automatic run_op(input bit st, input int a, input int e, input logic [15:0] m,
                        input logic [127:0] v, input bit poke);
    int off, lo, lat, bad_bytes;
    bit two;
    logic [127:0] exp_v;
    off = a % 8;
    lo  = a / 8;
    two = (off != 0);
    lat = st ? (two ? 6 : 4) : (two ? 4 : 3); // R2 R3
    exp_v = vout_model;
    if (!st) begin
      exp_v = v; // R7 base
      for (int j = 0; j < 16; j++) begin
        if (j >= e && m[j-e]) begin // R6
          int w;
          w = (j + off - e + 16) % 16;
          exp_v[127-8*j -: 8] = (!two && w >= 8) ? 8'h00 : ref_mem[win_addr(lo, w)]; // R5
        end
      end
      vout_model = exp_v;
    end else begin
      for (int k = 0; k < (two ? 16 : 8); k++) begin // R9 single doubleword when aligned
        if (k >= off && m[k-off]) // R8
          ref_mem[win_addr(lo, k)] = v[127-8*((k + e - off + 16) % 16) -: 8];
      end
    end
    is_store = st; addr = 12'(a); elem = 4'(e); byte_en = m; vreg_in = v; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    is_store = ~st; addr = 12'($urandom); elem = 4'($urandom);
    byte_en = 16'($urandom); vreg_in = {$urandom, $urandom, $urandom, $urandom};
    for (int n = 1; n <= lat; n++) begin
      if (poke) start = (n == 1); // R10 start while busy must be ignored
      chk(busy == (n < lat), "R10 busy schedule", 128'(busy), 128'(n < lat));
      chk(done == (n == lat), st ? (two ? "R3 store done" : "R2 store done")
                                 : (two ? "R3 load done" : "R2 load done"),
          128'(done), 128'(n == lat));
      if (n < lat) begin @(posedge clk); #1; end
    end
    start = 1'b0;
    chk(vreg_out == vout_model, st ? "R7 vreg_out held on store" : "R6 load result",
        vreg_out, vout_model);
    bad_bytes = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad_bytes++;
    chk(bad_bytes == 0, st ? "R8 R9 memory image" : "R11 memory unchanged by load",
        128'(bad_bytes), 128'(0));
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_store = 1'b0; addr = '0; elem = '0;
    byte_en = '0; vreg_in = '0;
    vout_model = '0;
    for (int i = 0; i < 4096; i++) ref_mem[i] = seed_byte(i);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done, "R1 busy/done after reset", 128'({busy, done}), 128'(0));
    chk(!mem_en && !mem_we, "R1 memory idle after reset", 128'({mem_en, mem_we}), 128'(0));
    chk(vreg_out == '0, "R1 vreg_out after reset", vreg_out, 128'(0));

    // loads
    run_op(0, 12'h100, 0, 16'hffff, {4{32'h0f1e2d3c}}, 0);   // R2 R4 R5 aligned
    run_op(0, 12'h123, 0, 16'hffff, '0, 0);                  // R3 unaligned
    run_op(0, 12'h245, 3, 16'h00f5, {4{32'hdeadbeef}}, 0);   // R6 R7 partial mask
    run_op(0, 12'h080, 5, 16'hffff, {4{32'h11223344}}, 0);   // R5 zero upper window, R9 shifted-out bits
    run_op(0, 12'hffd, 1, 16'hffff, {4{32'h55aa55aa}}, 0);   // R3 upper doubleword wraps to 0
    // stores
    run_op(1, 12'h300, 0, 16'hffff, 128'h000102030405060708090a0b0c0d0e0f, 0); // R2 R8
    run_op(1, 12'h316, 2, 16'hbeef, 128'h101112131415161718191a1b1c1d1e1f, 0); // R8
    run_op(1, 12'hffa, 9, 16'hffff, 128'h202122232425262728292a2b2c2d2e2f, 0); // R9 wrap
    run_op(1, 12'h407, 0, 16'hffff, 128'h303132333435363738393a3b3c3d3e3f, 0); // R9 discard
    run_op(1, 12'h500, 3, 16'hffff, 128'h404142434445464748494a4b4c4d4e4f, 0); // R9 single dw
    // start while busy
    run_op(0, 12'h611, 6, 16'h3c3c, {4{32'hcafef00d}}, 1);   // R10
    run_op(1, 12'h72b, 11, 16'hf0f0, {4{32'h89abcdef}}, 1);  // R10
    run_op(0, 12'h72b, 11, 16'hffff, '0, 0);                 // R8 readback
    // random mix
    for (int t = 0; t < 300; t++) begin
      run_op(1'($urandom), int'($urandom % 4096), int'($urandom % 16), 16'($urandom),
             {$urandom, $urandom, $urandom, $urandom}, 1'($urandom % 4 == 0));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule